// File: doc/BRIEF.md
# Serial FIFO trigger and flow-control logic

This block sits between the bus side and the bit shifters of a serial port. It holds two 16-entry byte queues. The bus writes the transmit queue and the transmit shifter drains it. The receive shifter fills the receive queue and the bus reads it. Each queue exposes its fill count.

Two sticky status flags tell software when to service the port. A receive-full flag rises once the receive queue holds at least a programmable number of bytes. A transmit-empty flag rises once the transmit queue has drained to a programmable number of remaining bytes or fewer. Software clears each flag with a clear strobe. The flag comes back the next cycle if its condition still holds.

The block also handles the request-to-send and clear-to-send handshake lines. With the handshake off, the line toward the peer is held low and the peer's line is ignored. With it on, the block holds off the peer when the receive queue is nearly full, and it allows a transmit start only while the peer signals clear. A synchronous queue-flush input empties both queues and leaves the configuration alone.

Top module: `sfifo_flow_ctrl`

## Requirements
- R1: Bytes leave each queue in the order they entered. `rx_rdata` and `tx_rdata` always show the oldest entry. Each count goes up by one per accepted push and down by one per accepted pop, and both change on the same clock edge.
- R2: A push while the count is 16 is ignored, and the count stays at 16. A pop while the count is 0 is ignored, and the count stays at 0.
- R3: The receive trigger level depends on `cfg_rx_trig`. In asynchronous mode (`cfg_sync`=0) the codes 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes. `rdf` becomes 1 on the clock edge after `rx_count` first reaches or exceeds the level.
- R4: In synchronous mode (`cfg_sync`=1) the receive trigger codes 0, 1, 2 and 3 select 1, 2, 8 and 14 bytes. The flag timing is the same as in R3.
- R5: The transmit trigger level depends on `cfg_tx_trig`. The codes 0, 1, 2 and 3 select 8, 4, 2 and 0 remaining bytes. `tdfe` becomes 1 on the clock edge after `tx_count` is at or below the level.
- R6: A cycle with `rdf_clr` (or `tdfe_clr`) high makes the flag 0 after that edge. If the flag's condition still holds, the flag is 1 again one edge later.
- R7: After reset, both counts are 0, both flags are 0, `rts_n` is 0 and `tx_start_ok` is 1. All configuration fields are 0, so the receive level is 1 byte and the transmit level is 8 bytes. `tdfe` therefore rises on the first edge after reset.
- R8: With `cfg_modem_en`=0, `rts_n` is 0 and `tx_start_ok` is 1, whatever the level of `cts_n` and the receive count.
- R9: With the handshake active, `rts_n` is 1 exactly while `rx_count` is 15 or more, and `tx_start_ok` equals the inverse of `cts_n`.
- R10: While `cfg_sync`=1 the handshake behaves as disabled (R8), even if `cfg_modem_en`=1.
- R11: A cycle with `fifo_clr` high empties both queues, so both counts are 0 after that edge. The configuration register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_clr | input | 1 | Flush both queues |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_rx_trig | input | 2 | Receive trigger code |
| cfg_tx_trig | input | 2 | Transmit trigger code |
| cfg_modem_en | input | 1 | Handshake enable |
| cfg_sync | input | 1 | 1 = synchronous mode |
| tx_push | input | 1 | Bus writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte from the bus |
| tx_pop | input | 1 | Shifter takes a transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter delivers a receive byte |
| rx_wdata | input | 8 | Receive byte from the shifter |
| rx_pop | input | 1 | Bus reads a receive byte |
| rx_rdata | output | 8 | Oldest receive byte |
| tx_count | output | 5 | Transmit queue fill |
| rx_count | output | 5 | Receive queue fill |
| rdf | output | 1 | Receive trigger flag |
| rdf_clr | input | 1 | Clear `rdf` |
| tdfe | output | 1 | Transmit trigger flag |
| tdfe_clr | input | 1 | Clear `tdfe` |
| cts_n | input | 1 | Peer clear-to-send, active low |
| rts_n | output | 1 | Request-to-send toward the peer, 1 = hold off |
| tx_start_ok | output | 1 | The shifter may begin a character |

## Verification
The assertions take it for granted that push and pop strobes are single-cycle pulses sampled on the rising edge. They also assume that `cts_n` is already synchronous to `clk` and that the configuration changes only through `cfg_we`. The stimulus drives every input one time unit after a rising edge and never changes `cts_n` close to an edge. It keeps a reference count in the bench and uses it to decide whether a push or pop is accepted, so that strobes into a full or empty queue are deliberate.

// File: rtl/sfc_pkg.sv
// Shared types and trigger-level decoding for the serial FIFO flow-control block.
// Assumes 16-entry queues: the trigger tables are defined for that depth.
package sfc_pkg;

    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_trig;
        logic       modem_en;
        logic       sync_mode;
    } sfc_cfg_t;

    // Receive level in bytes; the second code differs between modes
    function automatic logic [4:0] rx_level(input logic [1:0] code, input logic sync_mode);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return sync_mode ? 5'd2 : 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    // Transmit level as remaining bytes
    function automatic logic [4:0] tx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd8;
            2'd1:    return 5'd4;
            2'd2:    return 5'd2;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/sfc_byte_fifo.sv
// Show-ahead byte queue with a fill count.
// Pushes when full and pops when empty are dropped. clr flushes pointers and count.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module sfc_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Accept strobes only when there is room or data
    always_comb begin
        do_push = push && (count != FULL_CNT);
        do_pop  = pop  && (count != '0);
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and count update with flush
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/sfc_sticky_flag.sv
// Sticky status flag: set while cond holds, cleared by a strobe that wins for one cycle.
// Assumes cond comes from registered state.
module sfc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic flag
);
    // Clear has priority, otherwise set or hold
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else          flag <= flag | cond;
    end
endmodule

// File: rtl/sfc_modem_gate.sv
// Handshake gating: when inactive, the peer's line reads as clear and request-to-send is held low.
// Assumes cts_n is already synchronised to clk.
module sfc_modem_gate #(
    parameter int CW        = 5,
    parameter int RTS_LEVEL = 15
) (
    input  logic          active,
    input  logic          cts_n,
    input  logic [CW-1:0] rx_count,
    output logic          rts_n,
    output logic          tx_start_ok
);
    localparam logic [CW-1:0] RTS_CNT = CW'(RTS_LEVEL);

    // Force fixed line levels unless the handshake is active
    always_comb begin
        rts_n       = active && (rx_count >= RTS_CNT);
        tx_start_ok = active ? !cts_n : 1'b1;
    end
endmodule

// File: rtl/sfifo_flow_ctrl.sv
// Serial FIFO trigger and flow-control top.
// Holds the configuration register, both queues, both trigger flags and the handshake gating.
// Assumes DEPTH = 16 to match the trigger tables in sfc_pkg.
module sfifo_flow_ctrl #(
    parameter int W         = 8,
    parameter int DEPTH     = 16,
    parameter int RTS_LEVEL = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_clr,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_rx_trig,
    input  logic [1:0]                 cfg_tx_trig,
    input  logic                       cfg_modem_en,
    input  logic                       cfg_sync,
    input  logic                       tx_push,
    input  logic [W-1:0]               tx_wdata,
    input  logic                       tx_pop,
    output logic [W-1:0]               tx_rdata,
    input  logic                       rx_push,
    input  logic [W-1:0]               rx_wdata,
    input  logic                       rx_pop,
    output logic [W-1:0]               rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rdf,
    input  logic                       rdf_clr,
    output logic                       tdfe,
    input  logic                       tdfe_clr,
    input  logic                       cts_n,
    output logic                       rts_n,
    output logic                       tx_start_ok
);
    import sfc_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    sfc_cfg_t      cfg_q;
    logic          modem_eff;
    logic          rx_hit, tx_hit;
    logic [CW-1:0] rx_lvl, tx_lvl;

    // Configuration register, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= '{rx_trig: cfg_rx_trig, tx_trig: cfg_tx_trig,
                                    modem_en: cfg_modem_en, sync_mode: cfg_sync};
    end

    // Trigger thresholds and the handshake enable, which sync mode overrides
    always_comb begin
        rx_lvl    = CW'(rx_level(cfg_q.rx_trig, cfg_q.sync_mode));
        tx_lvl    = CW'(tx_level(cfg_q.tx_trig));
        rx_hit    = rx_count >= rx_lvl;
        tx_hit    = tx_count <= tx_lvl;
        modem_eff = cfg_q.modem_en && !cfg_q.sync_mode;
    end

    sfc_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count)
    );

    sfc_byte_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count)
    );

    sfc_sticky_flag u_rdf (
        .clk(clk), .rst_n(rst_n), .cond(rx_hit), .clr(rdf_clr), .flag(rdf)
    );

    sfc_sticky_flag u_tdfe (
        .clk(clk), .rst_n(rst_n), .cond(tx_hit), .clr(tdfe_clr), .flag(tdfe)
    );

    sfc_modem_gate #(.CW(CW), .RTS_LEVEL(RTS_LEVEL)) u_modem (
        .active(modem_eff), .cts_n(cts_n), .rx_count(rx_count),
        .rts_n(rts_n), .tx_start_ok(tx_start_ok)
    );

endmodule

// File: rtl/sfc_checker.sv
// Property checker for sfifo_flow_ctrl, attached through bind.
// Assumes strobes are sampled on the rising edge and cts_n is synchronous.
module sfc_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          rdf,
    input logic          rdf_clr,
    input logic          tdfe,
    input logic          tdfe_clr,
    input logic          cts_n,
    input logic          rts_n,
    input logic          tx_start_ok,
    input logic          modem_eff
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == 5'd16 && tx_push && !tx_pop && !fifo_clr) |=> tx_count == 5'd16); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == 5'd0 && rx_pop && !rx_push) |=> rx_count == 5'd0); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (tx_count == 5'd0 && rx_count == 5'd0)); // R11
    AST_RDF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rdf_clr |=> !rdf); // R6
    AST_TDFE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tdfe_clr |=> !tdfe); // R6
    AST_RTS_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_eff |-> !rts_n); // R8
    AST_CTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_eff |-> tx_start_ok); // R10
    AST_RTS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_eff && rx_count >= 5'd15) |-> rts_n); // R9
    AST_CTS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        modem_eff |-> (tx_start_ok == !cts_n)); // R9
endmodule

bind sfifo_flow_ctrl sfc_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_count(tx_count), .rx_count(rx_count),
    .rdf(rdf), .rdf_clr(rdf_clr), .tdfe(tdfe), .tdfe_clr(tdfe_clr),
    .cts_n(cts_n), .rts_n(rts_n), .tx_start_ok(tx_start_ok), .modem_eff(modem_eff)
);

// File: tb/sfifo_flow_ctrl_tb.sv
// Scoreboard bench: drivers queue expected bytes, monitors compare them on the way out.
module sfifo_flow_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_clr = 0, cfg_we = 0, cfg_modem_en = 0, cfg_sync = 0;
    logic [1:0] cfg_rx_trig = 0, cfg_tx_trig = 0;
    logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [7:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       rdf, tdfe, rdf_clr = 0, tdfe_clr = 0, cts_n = 1, rts_n, tx_start_ok;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int mdl_tx = 0, mdl_rx = 0;
    logic [7:0] tx_q[$], rx_q[$];
    logic [7:0] seed = 8'h3c;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfifo_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .cfg_we(cfg_we),
        .cfg_rx_trig(cfg_rx_trig), .cfg_tx_trig(cfg_tx_trig),
        .cfg_modem_en(cfg_modem_en), .cfg_sync(cfg_sync),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .rdf(rdf), .rdf_clr(rdf_clr), .tdfe(tdfe), .tdfe_clr(tdfe_clr),
        .cts_n(cts_n), .rts_n(rts_n), .tx_start_ok(tx_start_ok)
    );

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int rxt, input int txt, input bit me, input bit sy);
        cfg_we = 1; cfg_rx_trig = 2'(rxt); cfg_tx_trig = 2'(txt);
        cfg_modem_en = me; cfg_sync = sy;
        tick; cfg_we = 0;
    endtask

    task automatic flush;
        fifo_clr = 1; tick; fifo_clr = 0;
        tx_q.delete(); rx_q.delete(); mdl_tx = 0; mdl_rx = 0;
        chk("R11 flush tx", tx_count, 0);
        chk("R11 flush rx", rx_count, 0);
    endtask

    task automatic pulse_rdf_clr;  rdf_clr = 1;  tick; rdf_clr = 0;  endtask
    task automatic pulse_tdfe_clr; tdfe_clr = 1; tick; tdfe_clr = 0; endtask

    // Driver: shifter side delivers a receive byte
    task automatic drv_rx(input string req);
        seed = seed * 8'd5 + 8'd17;
        rx_push = 1; rx_wdata = seed; tick; rx_push = 0;
        if (mdl_rx < 16) begin rx_q.push_back(seed); mdl_rx++; end
        chk(req, rx_count, mdl_rx);
    endtask

    // Monitor: bus side reads the oldest receive byte and compares it
    task automatic mon_rx(input string req);
        if (mdl_rx > 0) chk("R1 rx order", rx_rdata, rx_q[0]);
        rx_pop = 1; tick; rx_pop = 0;
        if (mdl_rx > 0) begin void'(rx_q.pop_front()); mdl_rx--; end
        chk(req, rx_count, mdl_rx);
    endtask

    task automatic drv_tx(input string req);
        seed = seed * 8'd5 + 8'd17;
        tx_push = 1; tx_wdata = seed; tick; tx_push = 0;
        if (mdl_tx < 16) begin tx_q.push_back(seed); mdl_tx++; end
        chk(req, tx_count, mdl_tx);
    endtask

    task automatic mon_tx(input string req);
        if (mdl_tx > 0) chk("R1 tx order", tx_rdata, tx_q[0]);
        tx_pop = 1; tick; tx_pop = 0;
        if (mdl_tx > 0) begin void'(tx_q.pop_front()); mdl_tx--; end
        chk(req, tx_count, mdl_tx);
    endtask

    function automatic int rx_lvl_ref(input int code, input bit sy);
        case (code)
            0: return 1;
            1: return sy ? 2 : 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int tx_lvl_ref(input int code);
        case (code)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst_n = 1;
        // R7 reset state, then tdfe rises on the first edge
        chk("R7 tx_count", tx_count, 0);
        chk("R7 rx_count", rx_count, 0);
        chk("R7 rdf", rdf, 0);
        chk("R7 tdfe", tdfe, 0);
        chk("R7 rts_n", rts_n, 0);
        chk("R7 tx_start_ok", tx_start_ok, 1);
        tick;
        chk("R7 tdfe after first edge", tdfe, 1);
        // R7 default receive level of one byte
        drv_rx("R1 rx count");
        tick;
        chk("R7 default rx level", rdf, 1);
        mon_rx("R1 rx count");
        pulse_rdf_clr;

        // R3 and R4 receive trigger levels in both modes
        for (int sy = 0; sy < 2; sy++) begin
            for (int code = 0; code < 4; code++) begin
                int lvl;
                string tag;
                lvl = rx_lvl_ref(code, sy[0]);
                tag = sy ? "R4" : "R3";
                set_cfg(code, 0, 0, sy[0]);
                pulse_rdf_clr;
                for (int i = 0; i < lvl - 1; i++) drv_rx("R1 rx count");
                tick;
                chk({tag, " below level"}, rdf, 0);
                drv_rx("R1 rx count");
                chk({tag, " one edge lag"}, rdf, 0);
                tick;
                chk({tag, " at level"}, rdf, 1);
                pulse_rdf_clr;
                chk("R6 rdf cleared", rdf, 0);
                tick;
                chk("R6 rdf sets again", rdf, 1);
                for (int i = 0; i < lvl; i++) mon_rx("R1 rx count");
                pulse_rdf_clr;
                tick;
                chk("R6 rdf stays clear", rdf, 0);
            end
        end
        // R2 pop from empty receive queue
        mon_rx("R2 rx empty pop");

        // R5 transmit trigger levels
        set_cfg(0, 0, 0, 0);
        for (int code = 0; code < 4; code++) begin
            int lvl;
            lvl = tx_lvl_ref(code);
            set_cfg(0, code, 0, 0);
            for (int i = 0; i < 16; i++) drv_tx("R1 tx count");
            if (code == 0) drv_tx("R2 tx full push");
            pulse_tdfe_clr;
            tick;
            chk("R5 tdfe clear when full", tdfe, 0);
            for (int i = 0; i < 16 - lvl - 1; i++) mon_tx("R1 tx count");
            tick;
            chk("R5 above level", tdfe, 0);
            mon_tx("R1 tx count");
            tick;
            chk("R5 at level", tdfe, 1);
            pulse_tdfe_clr;
            chk("R6 tdfe cleared", tdfe, 0);
            tick;
            chk("R6 tdfe sets again", tdfe, 1);
            for (int i = 0; i < lvl; i++) mon_tx("R1 tx count");
        end
        mon_tx("R2 tx empty pop");

        // R9 handshake active
        set_cfg(0, 0, 1, 0);
        for (int i = 0; i < 14; i++) drv_rx("R1 rx count");
        chk("R9 rts low at 14", rts_n, 0);
        drv_rx("R1 rx count");
        chk("R9 rts high at 15", rts_n, 1);
        drv_rx("R1 rx count");
        chk("R9 rts high at 16", rts_n, 1);
        mon_rx("R1 rx count");
        mon_rx("R1 rx count");
        chk("R9 rts low at 14 again", rts_n, 0);
        cts_n = 1; #1;
        chk("R9 cts high blocks", tx_start_ok, 0);
        cts_n = 0; #1;
        chk("R9 cts low allows", tx_start_ok, 1);
        // R8 handshake disabled
        drv_rx("R1 rx count");
        drv_rx("R1 rx count");
        set_cfg(0, 0, 0, 0);
        cts_n = 1; #1;
        chk("R8 rts held low", rts_n, 0);
        chk("R8 cts ignored", tx_start_ok, 1);
        // R10 sync mode overrides the enable
        set_cfg(0, 0, 1, 1);
        chk("R10 rts held low", rts_n, 0);
        chk("R10 cts ignored", tx_start_ok, 1);
        flush;

        // R11 flush keeps configuration
        set_cfg(3, 0, 0, 0);
        for (int i = 0; i < 5; i++) drv_rx("R1 rx count");
        for (int i = 0; i < 3; i++) drv_tx("R1 tx count");
        flush;
        pulse_rdf_clr;
        for (int i = 0; i < 13; i++) drv_rx("R1 rx count");
        tick;
        chk("R11 level kept at 14", rdf, 0);
        drv_rx("R1 rx count");
        tick;
        chk("R11 level 14 reached", rdf, 1);
        for (int i = 0; i < 14; i++) mon_rx("R1 rx count");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule